// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupts

This block serves a parameterised number of general-purpose pins from one register bus. Every pin owns a small register group: a configuration word that holds the output enable, a data word that returns the synchronised input and holds the driven value, an interrupt-setup word, and a latched event flag. A separate routing word per pin picks which processor receives the pin's interrupt. Each input passes through a two-stage synchroniser. A per-pin detector then recognises a level or a single-polarity edge.

Recording an event and signalling it are two independent choices. An event sets the pin's flag only when the pin's recording control is on. It reaches the shared interrupt line only when the pin's interrupt enable is on and the pin is routed to the main processor. Software finds the sources by scanning the flags, and acknowledges one by writing a 1 to its flag.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, except each routing word, which reads 7. `pin_oe`, `pin_out` and `irq_summary` are 0.
- R2: Bit 9 of a pin's configuration word (offset 0x1000 + 0x10·n) drives `pin_oe[n]`. Bit 1 of its data word (offset 0x1004 + 0x10·n) drives `pin_out[n]`. Both read back as written.
- R3: Bit 0 of the data word returns `pin_in[n]` after a two-flop synchroniser. A change driven between clock edges first shows in `bus_rdata` after the third rising edge.
- R4: The interrupt-setup word (offset 0x1008 + 0x10·n) has four bits: bit 0 enable, bit 1 polarity (1 = rising or high), bit 2 mode (1 = edge, 0 = level) and bit 3 record. In edge mode with record = 1, an edge of the selected polarity sets bit 0 of the flag word (offset 0x100C + 0x10·n). An edge of the other polarity does not.
- R5: With record = 0, no event changes the flag word.
- R6: In edge mode with enable = 1, record = 0 and routing 4, a qualifying edge raises `irq_summary` for exactly one cycle while the flag stays 0.
- R7: In level mode with enable = 1 and routing 4, `irq_summary` is high while the synchronised input equals the polarity bit and low otherwise. With record = 1 the flag stays latched after the level ends.
- R8: The routing word for pin n is at offset 0x400 + 4·n, 3 bits wide. A pin contributes to `irq_summary` only while its routing word holds 4; 7 and any other code block it.
- R9: Writing a flag word with bit 0 = 1 clears the flag, and writing bit 0 = 0 has no effect. When a clear lands in the same cycle as a new recorded event, the flag stays set.
- R10: `irq_summary` is the OR over pins of enable, routing 4 and pending. It stays high until the last pending routed pin is cleared. A pin with enable = 0 never raises it.
- R11: A read of an address that maps to no register, including an address with a nonzero low two bits, returns 0.
- R12: `bus_rdata` is registered: it shows the word addressed in the cycle before the latest rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq_summary | output | 1 | Shared interrupt line to the main processor |

## Verification
The assertions check several properties on every cycle. The synchroniser chain must advance one stage per cycle. A flag may rise only when recording was on. A set flag may fall only after a clear write. An output-enable write must take effect on the next cycle. An unrouted bank must keep the summary low, and an unmapped read must return zero. Other behaviour only the bench's scenarios can show: that an edge of the wrong polarity is ignored, and the exact single-cycle pulse when recording is off. They also show level tracking, a clear losing to a simultaneous event, and the summary staying high while a second pin remains pending. Those need pin stimulus and exact timing.

// File: rtl/gpio_irq_pkg.sv
// Shared constants and types for the GPIO interrupt bank.
// Assumes byte addressing with 32-bit aligned registers.
package gpio_irq_pkg;

    // Address map anchors
    localparam int unsigned PIN_BASE   = 32'h1000;  // per-pin groups, 16-byte stride
    localparam int unsigned ROUTE_BASE = 32'h0400;  // routing words, 4-byte stride

    // Bit positions inside the per-pin words
    localparam int CFG_OE_BIT = 9;
    localparam int IO_IN_BIT  = 0;
    localparam int IO_OUT_BIT = 1;
    localparam int IC_EN      = 0;
    localparam int IC_POL     = 1;
    localparam int IC_EDGE    = 2;
    localparam int IC_REC     = 3;
    localparam int ICFG_W     = 4;

    // Routing codes
    localparam int ROUTE_W = 3;
    localparam logic [ROUTE_W-1:0] ROUTE_MAIN = 3'd4;
    localparam logic [ROUTE_W-1:0] ROUTE_NONE = 3'd7;

    // Word select inside one pin group
    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_IO   = 2'd1,
        SEL_ICFG = 2'd2,
        SEL_FLAG = 2'd3
    } word_sel_e;

    // Per-pin write strobes produced by the decoder
    typedef struct packed {
        logic cfg;
        logic io;
        logic icfg;
        logic flag;
        logic route;
    } pin_wr_t;

    // Write-data fields a pin slice consumes
    typedef struct packed {
        logic                oe_v;
        logic                out_v;
        logic [ICFG_W-1:0]   icfg;
        logic                clr;
        logic [ROUTE_W-1:0]  route;
    } wr_field_t;

    // Stored per-pin state returned for reads
    typedef struct packed {
        logic                oe;
        logic                out_v;
        logic [ICFG_W-1:0]   icfg;
        logic                flag;
        logic [ROUTE_W-1:0]  route;
    } pin_state_t;

endpackage

// File: rtl/gpio_input_sync.sv
// Two-flop synchroniser for all pin inputs.
// Assumes inputs are asynchronous; no metastability modelling.
module gpio_input_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_sync
);

    logic [NUM_PINS-1:0] stage1_q;
    logic [NUM_PINS-1:0] stage2_q;

    // Shift the raw inputs through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= pin_in;
            stage2_q <= stage1_q;
        end
    end

    assign pin_sync = stage2_q;

    // R3: second stage always equals the first stage one cycle earlier
    p_sync_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stage2_q == $past(stage1_q));

endmodule

// File: rtl/gpio_bus_decode.sv
// Address decoder: per-pin write strobes, read hits and word select.
// Assumes the routing window and the pin window do not overlap.
module gpio_bus_decode
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 16
) (
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    output pin_wr_t   [NUM_PINS-1:0]     wr_v,
    output logic      [NUM_PINS-1:0]     hit_pin,
    output logic      [NUM_PINS-1:0]     hit_route,
    output word_sel_e                    sel,
    output logic                         any_hit
);

    logic aligned;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign sel     = word_sel_e'(bus_addr[3:2]);

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        localparam logic [ADDR_W-5:0] PIN_TAG   = (ADDR_W-4)'((PIN_BASE >> 4) + n);
        localparam logic [ADDR_W-3:0] ROUTE_TAG = (ADDR_W-2)'((ROUTE_BASE >> 2) + n);

        // Match this pin's group and routing word
        always_comb begin
            hit_pin[n]     = aligned && (bus_addr[ADDR_W-1:4] == PIN_TAG);
            hit_route[n]   = aligned && (bus_addr[ADDR_W-1:2] == ROUTE_TAG);
            wr_v[n].cfg    = bus_wr && hit_pin[n] && (sel == SEL_CFG);
            wr_v[n].io     = bus_wr && hit_pin[n] && (sel == SEL_IO);
            wr_v[n].icfg   = bus_wr && hit_pin[n] && (sel == SEL_ICFG);
            wr_v[n].flag   = bus_wr && hit_pin[n] && (sel == SEL_FLAG);
            wr_v[n].route  = bus_wr && hit_route[n];
        end
    end

    assign any_hit = |{hit_pin, hit_route};

endmodule

// File: rtl/gpio_pin_slice.sv
// One pin: stored registers, event detection, flag and pending terms.
// Assumes pin_sync is already synchronised to clk.
module gpio_pin_slice
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pin_wr_t    wr,
    input  wr_field_t  wf,
    input  logic       pin_sync,
    output pin_state_t state,
    output logic       pending,
    output logic       routed
);

    logic               oe_q;
    logic               out_q;
    logic [ICFG_W-1:0]  icfg_q;
    logic               flag_q;
    logic [ROUTE_W-1:0] route_q;
    logic               prev_q;
    logic               edge_hit;
    logic               lvl_hit;
    logic               event_now;
    logic               set_flag;
    logic               clr_flag;

    // Software-written configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q    <= 1'b0;
            out_q   <= 1'b0;
            icfg_q  <= '0;
            route_q <= ROUTE_NONE;
        end else begin
            if (wr.cfg)   oe_q    <= wf.oe_v;
            if (wr.io)    out_q   <= wf.out_v;
            if (wr.icfg)  icfg_q  <= wf.icfg;
            if (wr.route) route_q <= wf.route;
        end
    end

    // Previous synchronised input for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_sync;
    end

    // Classify the current cycle's event
    always_comb begin
        edge_hit  = icfg_q[IC_POL] ? (pin_sync && !prev_q) : (!pin_sync && prev_q);
        lvl_hit   = (pin_sync == icfg_q[IC_POL]);
        event_now = icfg_q[IC_EDGE] ? edge_hit : lvl_hit;
        set_flag  = event_now && icfg_q[IC_REC];
        clr_flag  = wr.flag && wf.clr;
    end

    // Latched flag: a new recorded event outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= set_flag || (flag_q && !clr_flag);
    end

    // Pending and routing qualifiers for the summary line
    always_comb begin
        pending = icfg_q[IC_EDGE] ? (flag_q || edge_hit) : lvl_hit;
        routed  = icfg_q[IC_EN] && (route_q == ROUTE_MAIN);
    end

    assign state = '{oe: oe_q, out_v: out_q, icfg: icfg_q, flag: flag_q, route: route_q};

    // R5: the flag can only rise when recording was on
    p_flag_needs_record_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(icfg_q[IC_REC]));

    // R9: a set flag survives every cycle without a clear write
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr.flag && wf.clr)) |=> flag_q);

    // R9: a clear with recording off always empties the flag
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.flag && wf.clr && !icfg_q[IC_REC]) |=> !flag_q);

    // R2: a configuration write sets the output enable on the next cycle
    p_oe_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr.cfg |=> (state.oe == $past(wf.oe_v)));

endmodule

// File: rtl/gpio_irq_bank.sv
// GPIO bank top: decoder, synchroniser, one slice per pin, read mux
// and the registered summary interrupt.
// Assumes DATA_W > 9 and ADDR_W large enough for both windows.
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_summary
);

    pin_wr_t    [NUM_PINS-1:0] wr_v;
    logic       [NUM_PINS-1:0] hit_pin;
    logic       [NUM_PINS-1:0] hit_route;
    word_sel_e                 sel;
    logic                      any_hit;
    logic       [NUM_PINS-1:0] pin_sync;
    pin_state_t [NUM_PINS-1:0] st_v;
    logic       [NUM_PINS-1:0] pending_v;
    logic       [NUM_PINS-1:0] routed_v;
    wr_field_t                 wf;
    logic                      unused_wdata;
    logic       [DATA_W-1:0]   rd_word;
    logic       [DATA_W-1:0]   rdata_q;
    logic                      irq_q;

    // Pick out the write-data fields the slices consume
    always_comb begin
        wf.oe_v  = bus_wdata[CFG_OE_BIT];
        wf.out_v = bus_wdata[IO_OUT_BIT];
        wf.icfg  = bus_wdata[ICFG_W-1:0];
        wf.clr   = bus_wdata[0];
        wf.route = bus_wdata[ROUTE_W-1:0];
    end
    assign unused_wdata = ^{bus_wdata[DATA_W-1:CFG_OE_BIT+1], bus_wdata[CFG_OE_BIT-1:ICFG_W]};

    gpio_bus_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_decode (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .wr_v      (wr_v),
        .hit_pin   (hit_pin),
        .hit_route (hit_route),
        .sel       (sel),
        .any_hit   (any_hit)
    );

    gpio_input_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_slice
        gpio_pin_slice u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_v[n]),
            .wf       (wf),
            .pin_sync (pin_sync[n]),
            .state    (st_v[n]),
            .pending  (pending_v[n]),
            .routed   (routed_v[n])
        );
        assign pin_out[n] = st_v[n].out_v;
        assign pin_oe[n]  = st_v[n].oe;
    end

    // Format one pin-group word for the read mux
    function automatic logic [DATA_W-1:0] group_word(pin_state_t s, logic in_v, word_sel_e w);
        logic [DATA_W-1:0] v;
        v = '0;
        case (w)
            SEL_CFG:  v[CFG_OE_BIT] = s.oe;
            SEL_IO:   begin v[IO_IN_BIT] = in_v; v[IO_OUT_BIT] = s.out_v; end
            SEL_ICFG: v[ICFG_W-1:0] = s.icfg;
            default:  v[0] = s.flag;
        endcase
        return v;
    endfunction

    // Combine the one-hot read hits into a single word
    always_comb begin
        rd_word = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            if (hit_pin[n])
                rd_word = rd_word | group_word(st_v[n], pin_sync[n], sel);
            if (hit_route[n])
                rd_word = rd_word | DATA_W'(st_v[n].route);
        end
    end

    // Register the read data and the summary interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            rdata_q <= rd_word;
            irq_q   <= |(routed_v & pending_v);
        end
    end

    assign bus_rdata   = rdata_q;
    assign irq_summary = irq_q;

    // R8: with no pin enabled and routed, the summary stays low next cycle
    p_unrouted_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|routed_v) |=> !irq_summary);

    // R11: an address that hits nothing reads back as zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |=> (bus_rdata == '0));

    // R11: at most one pin group is addressed at a time
    p_single_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_pin));

endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

    localparam int N  = 8;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq_summary;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic          m_oe   [N];
    logic          m_out  [N];
    logic [3:0]    m_icfg [N];
    logic [2:0]    m_route[N];

    always #5 clk = ~clk;

    gpio_irq_bank #(.NUM_PINS(N), .ADDR_W(AW), .DATA_W(DW)) i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_summary(irq_summary)
    );

    function automatic logic [AW-1:0] grp(int n, int w);
        return AW'(32'h1000 + 16 * n + 4 * w);
    endfunction

    function automatic logic [AW-1:0] rte(int n);
        return AW'(32'h0400 + 4 * n);
    endfunction

    // Expected read value from the bench model (pins held static)
    function automatic logic [DW-1:0] model_read(logic [AW-1:0] a);
        for (int n = 0; n < N; n++) begin
            if (a == grp(n, 0)) return DW'(m_oe[n]) << 9;
            if (a == grp(n, 1)) return DW'({m_out[n], pin_in[n]});
            if (a == grp(n, 2)) return DW'(m_icfg[n]);
            if (a == grp(n, 3)) return '0;
            if (a == rte(n))    return DW'(m_route[n]);
        end
        return '0;
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        for (int n = 0; n < N; n++) begin
            m_oe[n] = 0; m_out[n] = 0; m_icfg[n] = 0; m_route[n] = 3'd7;
        end
    endtask

    task automatic count_irq(int k, output int c);
        c = 0;
        repeat (k) begin
            @(negedge clk);
            if (irq_summary) c++;
        end
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] d;
        int c;
        void'($urandom(32'h5eed));
        do_reset();

        // R1: reset state
        chk("R1 pin_oe", DW'(pin_oe), '0);
        chk("R1 pin_out", DW'(pin_out), '0);
        chk("R1 irq", DW'(irq_summary), '0);
        for (int n = 0; n < N; n++) begin
            rd(rte(n), d);      chk("R1 route", d, 32'd7);
            rd(grp(n, 2), d);   chk("R1 icfg", d, '0);
            rd(grp(n, 3), d);   chk("R1 flag", d, '0);
        end

        // R3: synchroniser latency seen at the bus
        @(negedge clk);
        bus_addr = grp(0, 1);
        pin_in[0] = 1'b1;
        @(negedge clk); chk("R3 after edge1", DW'(bus_rdata[0]), 32'd0);
        @(negedge clk); chk("R3 after edge2", DW'(bus_rdata[0]), 32'd0);
        @(negedge clk); chk("R3 after edge3", DW'(bus_rdata[0]), 32'd1);
        pin_in = 8'hA5;
        idle(4);
        for (int n = 0; n < N; n++) begin
            rd(grp(n, 1), d);
            chk("R3 input pattern", DW'(d[0]), DW'(pin_in[n]));
        end
        pin_in = '0;
        idle(4);

        // R2/R11: constrained random register traffic with pins static
        for (int i = 0; i < 300; i++) begin
            int n;
            int kind;
            logic [DW-1:0] v;
            logic [AW-1:0] a;
            n = int'($urandom_range(N - 1));
            kind = int'($urandom_range(5));
            v = $urandom;
            case (kind)
                0: begin wr(grp(n, 0), v); m_oe[n] = v[9]; end
                1: begin wr(grp(n, 1), v); m_out[n] = v[1]; end
                2: begin v[3] = 1'b0; wr(grp(n, 2), v); m_icfg[n] = v[3:0]; end
                3: begin wr(rte(n), v); m_route[n] = v[2:0]; end
                4: wr(grp(n, 3), v);
                default: ;
            endcase
            if ($urandom_range(3) == 0) a = AW'($urandom);
            else a = ($urandom_range(1) == 0) ? grp(int'($urandom_range(N - 1)), int'($urandom_range(3)))
                                              : rte(int'($urandom_range(N - 1)));
            rd(a, d);
            chk("R2/R11 random readback", d, model_read(a));
            for (int k = 0; k < N; k++) begin
                if (pin_oe[k] !== m_oe[k] || pin_out[k] !== m_out[k]) begin
                    chk("R2 pin outputs", DW'({pin_oe[k], pin_out[k]}), DW'({m_oe[k], m_out[k]}));
                end
            end
        end
        checks++;

        do_reset();

        // R2: directed output drive
        wr(grp(6, 0), 32'h200);
        wr(grp(6, 1), 32'h2);
        idle(1);
        chk("R2 oe pin6", DW'(pin_oe), 32'h40);
        chk("R2 out pin6", DW'(pin_out), 32'h40);

        // R4: rising edge with record on
        wr(rte(2), 32'd4);
        wr(grp(2, 2), 32'hF);
        @(negedge clk); pin_in[2] = 1'b1;
        idle(5);
        rd(grp(2, 3), d); chk("R4 rise sets flag", d, 32'd1);
        chk("R4 irq on rise", DW'(irq_summary), 32'd1);

        // R9: write 0 keeps flag, write 1 clears
        wr(grp(2, 3), 32'h0);
        rd(grp(2, 3), d); chk("R9 write0 no effect", d, 32'd1);
        wr(grp(2, 3), 32'h1);
        idle(2);
        rd(grp(2, 3), d); chk("R9 clear", d, 32'd0);
        chk("R9 irq after clear", DW'(irq_summary), 32'd0);

        // R4: wrong polarity edge ignored
        @(negedge clk); pin_in[2] = 1'b0;
        idle(5);
        rd(grp(2, 3), d); chk("R4 falling ignored", d, 32'd0);
        chk("R4 irq falling ignored", DW'(irq_summary), 32'd0);

        // R4: falling polarity
        wr(grp(2, 2), 32'hD);
        @(negedge clk); pin_in[2] = 1'b1;
        idle(5);
        rd(grp(2, 3), d); chk("R4 rise ignored pol0", d, 32'd0);
        @(negedge clk); pin_in[2] = 1'b0;
        idle(5);
        rd(grp(2, 3), d); chk("R4 fall sets flag pol0", d, 32'd1);
        wr(grp(2, 3), 32'h1);

        // R5/R6: record off, enable on -> one-cycle pulse, flag stays 0
        wr(grp(2, 2), 32'h7);
        @(negedge clk); pin_in[2] = 1'b1;
        count_irq(10, c);
        chk("R6 single pulse", DW'(c), 32'd1);
        rd(grp(2, 3), d); chk("R5 flag untouched", d, 32'd0);
        @(negedge clk); pin_in[2] = 1'b0;
        idle(4);

        // R10: enable off blocks
        wr(grp(2, 2), 32'h6);
        @(negedge clk); pin_in[2] = 1'b1;
        count_irq(10, c);
        chk("R10 disabled no irq", DW'(c), 32'd0);
        @(negedge clk); pin_in[2] = 1'b0;
        idle(4);

        // R7: level mode, active high
        wr(grp(2, 2), 32'hB);
        idle(3);
        chk("R7 inactive level", DW'(irq_summary), 32'd0);
        @(negedge clk); pin_in[2] = 1'b1;
        idle(5);
        chk("R7 active level", DW'(irq_summary), 32'd1);
        @(negedge clk); pin_in[2] = 1'b0;
        idle(5);
        chk("R7 level released", DW'(irq_summary), 32'd0);
        rd(grp(2, 3), d); chk("R7 flag latched", d, 32'd1);
        wr(grp(2, 3), 32'h1);
        rd(grp(2, 3), d); chk("R7 flag cleared", d, 32'd0);

        // R8: routing gates the summary
        wr(grp(2, 2), 32'hF);
        @(negedge clk); pin_in[2] = 1'b1;
        idle(5);
        chk("R8 routed 4", DW'(irq_summary), 32'd1);
        wr(rte(2), 32'd7); idle(2);
        chk("R8 routed 7", DW'(irq_summary), 32'd0);
        wr(rte(2), 32'd5); idle(2);
        chk("R8 routed 5", DW'(irq_summary), 32'd0);
        wr(rte(2), 32'd4); idle(2);
        chk("R8 routed back", DW'(irq_summary), 32'd1);
        wr(grp(2, 3), 32'h1);
        @(negedge clk); pin_in[2] = 1'b0;
        idle(4);

        // R9: clear in the same cycle as a new edge leaves the flag set
        @(negedge clk); pin_in[2] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = grp(2, 3); bus_wdata = 32'h1; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd(grp(2, 3), d); chk("R9 set beats clear", d, 32'd1);
        wr(grp(2, 3), 32'h1);
        @(negedge clk); pin_in[2] = 1'b0;
        idle(4);

        // R10: summary OR across two pins
        wr(rte(5), 32'd4);
        wr(grp(5, 2), 32'hF);
        @(negedge clk); pin_in[2] = 1'b1; pin_in[5] = 1'b1;
        idle(5);
        chk("R10 two pending", DW'(irq_summary), 32'd1);
        wr(grp(2, 3), 32'h1); idle(2);
        chk("R10 one left", DW'(irq_summary), 32'd1);
        wr(grp(5, 3), 32'h1); idle(2);
        chk("R10 none left", DW'(irq_summary), 32'd0);

        // R11: unmapped and misaligned reads
        rd(16'h0000, d);             chk("R11 low addr", d, '0);
        rd(grp(N, 0), d);            chk("R11 past pin window", d, '0);
        rd(rte(N), d);               chk("R11 past route window", d, '0);
        rd(grp(2, 2) + 16'd2, d);    chk("R11 misaligned", d, '0);

        // R12: read data is registered
        rd(rte(3), d);
        @(negedge clk);
        bus_addr = grp(2, 2);
        #1;
        chk("R12 before edge", bus_rdata, 32'd7);
        @(negedge clk);
        chk("R12 after edge", bus_rdata, 32'hF);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule